// File: doc/BRIEF.md
# Memory security lock controller

This block guards a small nonvolatile store against an external programmer. The store has two areas: a data memory and a configuration area. A single lock bit decides whether the programmer may read or write either area. The programmer sets the lock with a dedicated command. Once the lock is set, every programmer access is refused. A refused read returns all-ones data, so no stored content reaches the programmer.

The host processor keeps its own read path into the data memory, and that path works whatever the lock state is. The host can read the lock bit from a status register. Writing that register has no effect on the bit. The only way to release the lock is a whole-device erase. The erase sweeps both areas to the blank value (all ones) one word per cycle and clears the lock on its final cycle.

The lock bit stands for a nonvolatile cell. The synchronous system reset therefore leaves it untouched; only its power-up value is 0. All outputs are registered. Both areas are written with one write port each so that block RAM can be inferred.

Top module: `sec_lock_ctrl`

## Requirements
- R1: While the lock is set, every programmer request (read, write or lock, to either area) and every request with the reserved op code 3 in any state gives a one-cycle `pg_deny` pulse in the cycle after the request, with no `pg_grant`; a refused write leaves the stored word unchanged.
- R2: A refused programmer read (op 0) raises `pg_rvalid` together with `pg_deny` and returns all ones on `pg_rdata`.
- R3: While the lock is clear and no erase is running, programmer reads (op 0) and writes (op 1) are granted with a one-cycle `pg_grant` pulse in the cycle after the request. `pg_sel_cfg`=1 addresses the configuration area through the low `CFG_AW` address bits. A granted read returns the last word written at that address.
- R4: The lock command (op 2) is granted only while the lock is clear and no erase is running, and sets the lock. While the lock is already set, the command is refused.
- R5: A host read (`hs_rd`) returns the data-memory word at `hs_addr` on `hs_rdata`, with `hs_rvalid` high, one cycle later, whether or not the lock is set.
- R6: A host status read (`hr_rd`) returns the lock bit in bit 0 and zeros elsewhere one cycle later; host status writes (`hr_wr`, `hr_wdata`) never change the lock.
- R7: A `chip_erase` accepted while idle keeps `erase_busy` high for exactly 2**`MEM_AW` cycles. Afterwards every word of both areas reads as all ones, the lock is clear, and programmer access is granted again.
- R8: Asserting `rst` clears the output pulses and any running erase but does not change the lock bit.
- R9: While an erase is running, programmer requests are refused and a further `chip_erase` neither restarts nor lengthens the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| pg_req | input | 1 | Programmer request strobe |
| pg_op | input | 2 | Programmer op: 0 read, 1 write, 2 lock, 3 reserved |
| pg_sel_cfg | input | 1 | 1 targets the configuration area, 0 the data memory |
| pg_addr | input | MEM_AW | Programmer word address |
| pg_wdata | input | DATA_W | Programmer write data |
| pg_grant | output | 1 | One-cycle pulse: request accepted |
| pg_deny | output | 1 | One-cycle pulse: request refused |
| pg_rvalid | output | 1 | Programmer read response valid |
| pg_rdata | output | DATA_W | Programmer read data (all ones when refused) |
| hs_rd | input | 1 | Host data-port read strobe |
| hs_addr | input | MEM_AW | Host data-port address |
| hs_rvalid | output | 1 | Host read response valid |
| hs_rdata | output | DATA_W | Host read data |
| hr_rd | input | 1 | Host status-register read strobe |
| hr_wr | input | 1 | Host status-register write strobe (ignored) |
| hr_wdata | input | DATA_W | Host status-register write data (ignored) |
| hr_rdata | output | DATA_W | Status register: bit 0 is the lock |
| chip_erase | input | 1 | Whole-device erase command |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
The bench looks for leaks through a locked programmer port. A design that let locked reads through would return real data instead of all ones. A design that let a locked write through would show the new word on the host port. It also checks that the host data port keeps working under the lock; a design that gated it would return the wrong word. The bench counts erase-busy cycles, and reissues the erase part way through, to catch a sweep that is too short or that restarts. After the erase it reads back blank words and a clear lock. It also asserts reset while locked and writes the status register, to catch a lock bit that is wrongly tied to reset or to host writes.

// File: rtl/sec_lock_pkg.sv
package sec_lock_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_LOCK  = 2'd2,
    OP_RSVD  = 2'd3
  } pg_op_e;
endpackage

// File: rtl/sec_lock_nvbit.sv
module sec_lock_nvbit (
  input  logic clk,
  input  logic set_i,
  input  logic clr_i,
  output logic locked_o
);
  // Nonvolatile cell: power-up value only, no link to the system reset.
  logic locked_q = 1'b0;

  always_ff @(posedge clk) begin
    if (clr_i)      locked_q <= 1'b0;
    else if (set_i) locked_q <= 1'b1;
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/sec_lock_eraser.sv
module sec_lock_eraser #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          busy_o,
  output logic [AW-1:0] idx_o,
  output logic          last_o
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic          busy_q;
  logic [AW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else begin
      if (idx_q == LAST) busy_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign last_o = busy_q && (idx_q == LAST);

  // R9
  erase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !last_o) |=> (busy_o && idx_o == $past(idx_o) + 1'b1));

  // R7
  erase_end_chk: assert property (@(posedge clk) disable iff (rst)
    last_o |=> !busy_o);
endmodule

// File: rtl/sec_lock_store.sv
module sec_lock_store #(
  parameter int AW    = 6,
  parameter int DW    = 8,
  parameter bit HAS_B = 1'b1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re_a,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic          re_b,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_a_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re_a) rd_a_q <= mem[raddr_a];
  end
  assign rdata_a = rd_a_q;

  generate
    if (HAS_B) begin : g_port_b
      logic [DW-1:0] rd_b_q;
      always_ff @(posedge clk) begin
        if (re_b) rd_b_q <= mem[raddr_b];
      end
      assign rdata_b = rd_b_q;
    end else begin : g_no_port_b
      logic unused_b;
      assign unused_b = re_b ^ (^raddr_b);
      assign rdata_b  = '0;
    end
  endgenerate
endmodule

// File: rtl/sec_lock_ctrl.sv
module sec_lock_ctrl
  import sec_lock_pkg::*;
#(
  parameter int MEM_AW = 6,
  parameter int CFG_AW = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pg_req,
  input  logic [1:0]        pg_op,
  input  logic              pg_sel_cfg,
  input  logic [MEM_AW-1:0] pg_addr,
  input  logic [DATA_W-1:0] pg_wdata,
  output logic              pg_grant,
  output logic              pg_deny,
  output logic              pg_rvalid,
  output logic [DATA_W-1:0] pg_rdata,
  input  logic              hs_rd,
  input  logic [MEM_AW-1:0] hs_addr,
  output logic              hs_rvalid,
  output logic [DATA_W-1:0] hs_rdata,
  input  logic              hr_rd,
  input  logic              hr_wr,
  input  logic [DATA_W-1:0] hr_wdata,
  output logic [DATA_W-1:0] hr_rdata,
  input  logic              chip_erase,
  output logic              erase_busy
);
  localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

  initial begin
    if (CFG_AW > MEM_AW) $error("CFG_AW must not exceed MEM_AW");
  end

  // ---------------- lock cell and erase sweep ----------------
  logic              locked;
  logic              busy;
  logic              sweep_last;
  logic [MEM_AW-1:0] sweep_idx;
  logic              lock_set;

  sec_lock_eraser #(.AW(MEM_AW)) u_eraser (
    .clk     (clk),
    .rst     (rst),
    .start_i (chip_erase),
    .busy_o  (busy),
    .idx_o   (sweep_idx),
    .last_o  (sweep_last)
  );

  sec_lock_nvbit u_lock (
    .clk      (clk),
    .set_i    (lock_set),
    .clr_i    (sweep_last),
    .locked_o (locked)
  );

  // ---------------- programmer access decision ----------------
  pg_op_e op;
  logic   open_ok, rd_ok, wr_ok, refuse, is_rd;

  assign op      = pg_op_e'(pg_op);
  assign open_ok = pg_req && !rst && !locked && !busy;
  assign rd_ok   = open_ok && (op == OP_READ);
  assign wr_ok   = open_ok && (op == OP_WRITE);
  assign lock_set = open_ok && (op == OP_LOCK);
  assign is_rd   = pg_req && !rst && (op == OP_READ);
  assign refuse  = pg_req && !rst && !(rd_ok || wr_ok || lock_set);

  // ---------------- storage ----------------
  logic [DATA_W-1:0] mem_rd_a, mem_rd_b, cfg_rd_a, cfg_unused_rd;

  sec_lock_store #(.AW(MEM_AW), .DW(DATA_W), .HAS_B(1'b1)) u_mem (
    .clk     (clk),
    .we      (busy || (wr_ok && !pg_sel_cfg)),
    .waddr   (busy ? sweep_idx : pg_addr),
    .wdata   (busy ? BLANK : pg_wdata),
    .re_a    (rd_ok && !pg_sel_cfg),
    .raddr_a (pg_addr),
    .rdata_a (mem_rd_a),
    .re_b    (hs_rd),
    .raddr_b (hs_addr),
    .rdata_b (mem_rd_b)
  );

  sec_lock_store #(.AW(CFG_AW), .DW(DATA_W), .HAS_B(1'b0)) u_cfg (
    .clk     (clk),
    .we      (busy || (wr_ok && pg_sel_cfg)),
    .waddr   (busy ? sweep_idx[CFG_AW-1:0] : pg_addr[CFG_AW-1:0]),
    .wdata   (busy ? BLANK : pg_wdata),
    .re_a    (rd_ok && pg_sel_cfg),
    .raddr_a (pg_addr[CFG_AW-1:0]),
    .rdata_a (cfg_rd_a),
    .re_b    (1'b0),
    .raddr_b ({CFG_AW{1'b0}}),
    .rdata_b (cfg_unused_rd)
  );

  // ---------------- registered responses ----------------
  logic grant_q, deny_q, rvalid_q, rd_refused_q, sel_cfg_q, hs_rvalid_q;
  logic [DATA_W-1:0] status_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q      <= 1'b0;
      deny_q       <= 1'b0;
      rvalid_q     <= 1'b0;
      rd_refused_q <= 1'b0;
      sel_cfg_q    <= 1'b0;
      hs_rvalid_q  <= 1'b0;
      status_q     <= '0;
    end else begin
      grant_q      <= rd_ok || wr_ok || lock_set;
      deny_q       <= refuse;
      rvalid_q     <= is_rd;
      rd_refused_q <= is_rd && !rd_ok;
      sel_cfg_q    <= pg_sel_cfg;
      hs_rvalid_q  <= hs_rd;
      if (hr_rd) status_q <= {{(DATA_W-1){1'b0}}, locked};
    end
  end

  // Host status writes reach nothing: the lock is read-only from the host.
  logic unused_hr;
  assign unused_hr = hr_wr ^ (^hr_wdata) ^ (^cfg_unused_rd);

  assign pg_grant   = grant_q;
  assign pg_deny    = deny_q;
  assign pg_rvalid  = rvalid_q;
  assign pg_rdata   = rd_refused_q ? BLANK : (sel_cfg_q ? cfg_rd_a : mem_rd_a);
  assign hs_rvalid  = hs_rvalid_q;
  assign hs_rdata   = mem_rd_b;
  assign hr_rdata   = status_q;
  assign erase_busy = busy;

  // R1
  locked_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (pg_req && locked) |=> (pg_deny && !pg_grant));

  // R2
  deny_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (pg_rvalid && pg_deny) |-> (pg_rdata == BLANK));

  // R4
  lock_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(pg_req && pg_op == OP_LOCK && !busy));

  // R6
  host_wr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (hr_wr && !lock_set && !sweep_last) |=> (locked == $past(locked)));

  // R9
  busy_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (pg_req && busy) |=> pg_deny);
endmodule

// File: tb/sec_lock_ctrl_tb.sv
module sec_lock_ctrl_tb;
  localparam int MEM_AW = 6;
  localparam int CFG_AW = 4;
  localparam int DW     = 8;
  localparam int SWEEP  = 2 ** MEM_AW;
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pg_req = 0, pg_sel_cfg = 0;
  logic [1:0] pg_op = 0;
  logic [MEM_AW-1:0] pg_addr = 0, hs_addr = 0;
  logic [DW-1:0] pg_wdata = 0, hr_wdata = 0;
  logic hs_rd = 0, hr_rd = 0, hr_wr = 0, chip_erase = 0;
  logic pg_grant, pg_deny, pg_rvalid, hs_rvalid, erase_busy;
  logic [DW-1:0] pg_rdata, hs_rdata, hr_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sec_lock_ctrl #(.MEM_AW(MEM_AW), .CFG_AW(CFG_AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .pg_req(pg_req), .pg_op(pg_op), .pg_sel_cfg(pg_sel_cfg),
    .pg_addr(pg_addr), .pg_wdata(pg_wdata),
    .pg_grant(pg_grant), .pg_deny(pg_deny), .pg_rvalid(pg_rvalid), .pg_rdata(pg_rdata),
    .hs_rd(hs_rd), .hs_addr(hs_addr), .hs_rvalid(hs_rvalid), .hs_rdata(hs_rdata),
    .hr_rd(hr_rd), .hr_wr(hr_wr), .hr_wdata(hr_wdata), .hr_rdata(hr_rdata),
    .chip_erase(chip_erase), .erase_busy(erase_busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      finish_run();
    end
  end

  // One programmer request; outputs sampled one cycle later.
  task automatic pg_access(input logic [1:0] op, input logic cfg,
                           input logic [MEM_AW-1:0] a, input logic [DW-1:0] d);
    pg_req = 1; pg_op = op; pg_sel_cfg = cfg; pg_addr = a; pg_wdata = d;
    @(negedge clk);
    pg_req = 0;
  endtask

  task automatic host_read(input logic [MEM_AW-1:0] a);
    hs_rd = 1; hs_addr = a;
    @(negedge clk);
    hs_rd = 0;
  endtask

  task automatic status_read();
    hr_rd = 1;
    @(negedge clk);
    hr_rd = 0;
  endtask

  task automatic t_reset_state();
    check("R6 reset status", hr_rdata, 0);
    check("R8 reset grant", pg_grant, 0);
    check("R8 reset deny", pg_deny, 0);
    check("R7 reset busy", erase_busy, 0);
    status_read();
    check("R6 power-up lock clear", hr_rdata, 0);
  endtask

  task automatic t_open_access();
    pg_access(2'd1, 0, 6'd5, 8'hA5);
    check("R3 write grant", {pg_grant, pg_deny}, 2'b10);
    pg_access(2'd1, 0, 6'd63, 8'h3C);
    pg_access(2'd1, 1, 6'd2, 8'h5A);
    check("R3 cfg write grant", pg_grant, 1);
    pg_access(2'd0, 0, 6'd5, 8'h00);
    check("R3 mem read grant", {pg_grant, pg_deny, pg_rvalid}, 3'b101);
    check("R3 mem read data", pg_rdata, 8'hA5);
    pg_access(2'd0, 1, 6'd2, 8'h00);
    check("R3 cfg read data", pg_rdata, 8'h5A);
    pg_access(2'd3, 0, 6'd5, 8'h00);
    check("R1 reserved op refused", {pg_grant, pg_deny}, 2'b01);
    host_read(6'd63);
    check("R5 host read unlocked", {hs_rvalid, hs_rdata}, {1'b1, 8'h3C});
  endtask

  task automatic t_host_write_ignored(input logic exp_lock);
    hr_wr = 1; hr_wdata = exp_lock ? 8'h00 : 8'hFF;
    @(negedge clk);
    hr_wr = 0;
    status_read();
    check("R6 host write ignored", hr_rdata, {7'd0, exp_lock});
  endtask

  task automatic t_set_lock();
    pg_access(2'd2, 0, 6'd0, 8'h00);
    check("R4 lock grant", {pg_grant, pg_deny}, 2'b10);
    status_read();
    check("R4 status locked", hr_rdata, 8'h01);
    pg_access(2'd2, 0, 6'd0, 8'h00);
    check("R4 relock refused", {pg_grant, pg_deny}, 2'b01);
  endtask

  task automatic t_locked_access();
    pg_access(2'd0, 0, 6'd5, 8'h00);
    check("R1 locked read deny", {pg_grant, pg_deny}, 2'b01);
    check("R2 locked read rvalid", pg_rvalid, 1);
    check("R2 locked read ones", pg_rdata, ONES);
    pg_access(2'd0, 1, 6'd2, 8'h00);
    check("R2 locked cfg read ones", pg_rdata, ONES);
    pg_access(2'd1, 0, 6'd5, 8'h11);
    check("R1 locked write deny", {pg_grant, pg_deny}, 2'b01);
    @(negedge clk);
    check("R1 deny is one cycle", pg_deny, 0);
    host_read(6'd5);
    check("R1 locked write had no effect", hs_rdata, 8'hA5);
    check("R5 host read while locked", hs_rvalid, 1);
  endtask

  task automatic t_reset_keeps_lock();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R8 pulses cleared", {pg_grant, pg_deny, pg_rvalid}, 3'b000);
    status_read();
    check("R8 lock survives reset", hr_rdata, 8'h01);
  endtask

  task automatic t_erase();
    int busy_cycles = 0;
    chip_erase = 1;
    @(negedge clk);
    chip_erase = 0;
    check("R7 busy after erase", erase_busy, 1);
    while (erase_busy && busy_cycles < 4 * SWEEP) begin
      busy_cycles++;
      if (busy_cycles == 10) begin
        pg_req = 1; pg_op = 2'd0; pg_sel_cfg = 0; pg_addr = 6'd5;
        chip_erase = 1;
      end
      @(negedge clk);
      if (busy_cycles == 10) begin
        pg_req = 0; chip_erase = 0;
        check("R9 request during erase refused", {pg_grant, pg_deny}, 2'b01);
      end
    end
    check("R9 R7 busy length", busy_cycles, SWEEP);
    status_read();
    check("R7 lock cleared by erase", hr_rdata, 0);
    host_read(6'd5);
    check("R7 mem blank", hs_rdata, ONES);
    host_read(6'd63);
    check("R7 last word blank", hs_rdata, ONES);
    pg_access(2'd0, 1, 6'd2, 8'h00);
    check("R7 access granted again", {pg_grant, pg_deny}, 2'b10);
    check("R7 cfg blank", pg_rdata, ONES);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset_state();
    t_open_access();
    t_host_write_ignored(1'b0);
    t_set_lock();
    t_locked_access();
    t_host_write_ignored(1'b1);
    t_reset_keeps_lock();
    t_erase();
    finish_run();
  end
endmodule